// File: doc/BRIEF.md
# Paging Translation Unit Control Registers

This block is the register-side front end of a paging address-translation unit. A host reaches it through a simple 32-bit register port with a single-cycle write strobe and a read strobe. Read data comes back one cycle after the read strobe. Through this port the host sets the page-directory base and writes encoded commands. These commands turn translation on or off, ask the engine to stall, flush its cached translations, acknowledge a handled page fault, or return the whole unit to its power-on settings.

On the engine side the block drives level controls (translation on, stall request), one-cycle pulses (flush all, flush one page, resume after fault) and the stored directory base. It takes back fault reports, bus read-error reports and two engine condition flags. Faults and bus errors set sticky raw interrupt bits. A mask selects which of those bits reach the interrupt line. The host clears a raw bit by writing a 1 to it. A small stored clock-gating word is kept for the engine and has no other effect here.

Top module: `pgu_ctrl_regs`

## Requirements
- R1: After reset, paging, stall and fault-active are 0, the status word reads 0x80000000 plus bit 3 = idle input and bit 4 = replay-empty input, the interrupt line is low and the directory base reads 0.
- R2: A write to offset 0x00 stores only bits 31:12 and clears bits 11:0, so writing 0xCAFEBABE reads back as 0xCAFEB000. The stored value is driven on `xl_dir_base`.
- R3: Command value 0 (written to offset 0x08) sets paging and command value 1 clears it. Each change is visible on `xl_paging` and in status bit 0 from the cycle after the write.
- R4: Command 2 sets the stall request and command 3 clears it. Status bit 2 shows the stall and bit 31 shows its inverse. Command 2 has no effect while a page fault is active.
- R5: Command 4 gives a one-cycle `xl_flush_all` pulse. A write to offset 0x10 gives a one-cycle `xl_flush_one` pulse, with the written word on `xl_flush_addr`.
- R6: A fault report sets fault-active (status bit 1) and raw interrupt bit 0. It also records the address (read at 0x0C), the write flag (status bit 5) and the requester ID (status bits 10:6). A later report overwrites the record.
- R7: Command 5 clears fault-active and gives a one-cycle `xl_resume` pulse. The raw bit and the recorded address, direction and ID stay as they were. A fault report in the same cycle keeps fault-active set and suppresses the pulse.
- R8: A bus-error report sets raw bit 1 (offset 0x14). Both raw bits can be pending together.
- R9: Masked status (offset 0x20) equals raw AND mask (offset 0x1C, bits 1:0). `irq` is high exactly when masked status is nonzero, in the same cycle the registers change.
- R10: Writing 1s to offset 0x18 clears the matching raw bits. An event arriving in the same cycle as the clear keeps its bit set.
- R11: Command 6 returns every stored register to its reset value. This includes directory base, mask, raw bits, fault record and gating word.
- R12: Read data is valid on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd`. Offset 0x24 stores a full 32-bit word. Offsets 0x08, 0x10 and 0x18 read as 0. A command value outside 0 to 6 changes nothing.
- R13: Status bits 3 and 4 follow the engine idle and replay-empty inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| eng_fault | input | 1 | Page fault report pulse |
| eng_fault_addr | input | 32 | Faulting address |
| eng_fault_wr | input | 1 | Faulting access was a write |
| eng_fault_id | input | ID_W | Faulting requester ID |
| eng_buserr | input | 1 | Bus read-error report pulse |
| eng_idle | input | 1 | Engine idle flag |
| eng_replay_empty | input | 1 | Engine replay buffer empty flag |
| xl_paging | output | 1 | Translation enabled |
| xl_stall | output | 1 | Stall request |
| xl_flush_all | output | 1 | Flush-all pulse |
| xl_flush_one | output | 1 | Single-page flush pulse |
| xl_flush_addr | output | 32 | Address for single-page flush |
| xl_resume | output | 1 | Resume-after-fault pulse |
| xl_dir_base | output | 32 | Page-directory base |
| gate_cfg | output | 32 | Stored clock-gating word |
| irq | output | 1 | Interrupt, high while masked status is nonzero |

## Verification
The bench builds the block with its default parameters: an 8-bit offset bus, a 5-bit requester ID and a directory base kept from bit 12. With these values the fault record can be driven with the all-ones ID 31, which fills status bits 10:6 to their edge without spilling into bit 11. The 0xCAFEBABE truncation case lands exactly on the 12-bit boundary. The same-cycle cases for clear against event and fault-done against new fault are driven on purpose, and so is a hard reset issued with every register loaded.

// File: rtl/pgu_pkg.sv
package pgu_pkg;
  localparam int REG_W = 32;
  localparam int IRQ_N = 2;

  localparam logic [7:0] OFS_BASE  = 8'h00;
  localparam logic [7:0] OFS_STAT  = 8'h04;
  localparam logic [7:0] OFS_CMD   = 8'h08;
  localparam logic [7:0] OFS_FADDR = 8'h0C;
  localparam logic [7:0] OFS_INV1  = 8'h10;
  localparam logic [7:0] OFS_RAW   = 8'h14;
  localparam logic [7:0] OFS_ICLR  = 8'h18;
  localparam logic [7:0] OFS_MASK  = 8'h1C;
  localparam logic [7:0] OFS_MSTAT = 8'h20;
  localparam logic [7:0] OFS_GATE  = 8'h24;

  typedef enum logic [2:0] {
    CMD_PAGE_ON    = 3'd0,
    CMD_PAGE_OFF   = 3'd1,
    CMD_STALL_ON   = 3'd2,
    CMD_STALL_OFF  = 3'd3,
    CMD_FLUSH_ALL  = 3'd4,
    CMD_FAULT_DONE = 3'd5,
    CMD_HARD_RST   = 3'd6
  } cmd_e;

  localparam int IRQ_FAULT  = 0;
  localparam int IRQ_BUSERR = 1;

  localparam int ST_PAGING  = 0;
  localparam int ST_FAULT   = 1;
  localparam int ST_STALL   = 2;
  localparam int ST_IDLE    = 3;
  localparam int ST_REPLAY  = 4;
  localparam int ST_FWRITE  = 5;
  localparam int ST_ID_LSB  = 6;
  localparam int ST_NSTALL  = 31;
endpackage

// File: rtl/pgu_cmd_ctrl.sv
module pgu_cmd_ctrl
  import pgu_pkg::*;
#(
  parameter int ID_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cmd_vld,
  input  logic [REG_W-1:0]  cmd_code,
  input  logic              fault_evt,
  input  logic [REG_W-1:0]  fault_addr,
  input  logic              fault_wr,
  input  logic [ID_W-1:0]   fault_id,
  output logic              paging_q,
  output logic              stall_q,
  output logic              fault_act_q,
  output logic              fault_wr_q,
  output logic [ID_W-1:0]   fault_id_q,
  output logic [REG_W-1:0]  fault_addr_q,
  output logic              flush_all_q,
  output logic              resume_q
);
  logic do_on, do_off, do_st_on, do_st_off, do_flush, do_done;
  logic wipe;

  assign wipe      = rst | clr;
  assign do_on     = cmd_vld && (cmd_code == REG_W'(CMD_PAGE_ON));
  assign do_off    = cmd_vld && (cmd_code == REG_W'(CMD_PAGE_OFF));
  assign do_st_on  = cmd_vld && (cmd_code == REG_W'(CMD_STALL_ON));
  assign do_st_off = cmd_vld && (cmd_code == REG_W'(CMD_STALL_OFF));
  assign do_flush  = cmd_vld && (cmd_code == REG_W'(CMD_FLUSH_ALL));
  assign do_done   = cmd_vld && (cmd_code == REG_W'(CMD_FAULT_DONE));

  always_ff @(posedge clk) begin
    if (wipe) begin
      paging_q <= 1'b0;
    end else if (do_on) begin
      paging_q <= 1'b1;
    end else if (do_off) begin
      paging_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wipe) begin
      stall_q <= 1'b0;
    end else if (do_st_on && !fault_act_q) begin
      stall_q <= 1'b1;
    end else if (do_st_off) begin
      stall_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wipe) begin
      fault_act_q  <= 1'b0;
      fault_wr_q   <= 1'b0;
      fault_id_q   <= '0;
      fault_addr_q <= '0;
    end else if (fault_evt) begin
      fault_act_q  <= 1'b1;
      fault_wr_q   <= fault_wr;
      fault_id_q   <= fault_id;
      fault_addr_q <= fault_addr;
    end else if (do_done) begin
      fault_act_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wipe) begin
      flush_all_q <= 1'b0;
      resume_q    <= 1'b0;
    end else begin
      flush_all_q <= do_flush;
      resume_q    <= do_done && !fault_evt;
    end
  end

  // R6: a fault report always leaves fault-active set
  a_r6_fault_latch: assert property (@(posedge clk) disable iff (rst)
    (fault_evt && !clr) |=> fault_act_q);

  // R4: stall request cannot rise while a fault is pending
  a_r4_stall_blocked: assert property (@(posedge clk) disable iff (rst)
    (do_st_on && fault_act_q && !clr) |=> $stable(stall_q));

  // R7: fault-done without a new fault releases the engine
  a_r7_done_release: assert property (@(posedge clk) disable iff (rst)
    (do_done && !fault_evt && !clr) |=> (!fault_act_q && resume_q));
endmodule

// File: rtl/pgu_irq_unit.sv
module pgu_irq_unit
  import pgu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [IRQ_N-1:0] ev,
  input  logic             ack_wr,
  input  logic [IRQ_N-1:0] ack_bits,
  input  logic             mask_wr,
  input  logic [IRQ_N-1:0] mask_bits,
  output logic [IRQ_N-1:0] raw_q,
  output logic [IRQ_N-1:0] mask_q,
  output logic             irq_q
);
  logic [IRQ_N-1:0] raw_d;
  logic [IRQ_N-1:0] mask_d;
  logic             wipe;

  assign wipe   = rst | clr;
  assign mask_d = mask_wr ? mask_bits : mask_q;

  for (genvar i = 0; i < IRQ_N; i++) begin : g_src
    assign raw_d[i] = ev[i] | (raw_q[i] & ~(ack_wr & ack_bits[i]));

    always_ff @(posedge clk) begin
      if (wipe) raw_q[i] <= 1'b0;
      else      raw_q[i] <= raw_d[i];
    end

    // R10: an event wins over a clear in the same cycle
    a_r10_event_wins: assert property (@(posedge clk) disable iff (rst)
      (ev[i] && !clr) |=> raw_q[i]);
  end

  always_ff @(posedge clk) begin
    if (wipe) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq_q  <= |(raw_d & mask_d);
    end
  end

  // R9: line level tracks the masked set every cycle
  a_r9_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(raw_q & mask_q));
endmodule

// File: rtl/pgu_rd_mux.sv
module pgu_rd_mux
  import pgu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  base_v,
  input  logic [REG_W-1:0]  stat_v,
  input  logic [REG_W-1:0]  faddr_v,
  input  logic [IRQ_N-1:0]  raw_v,
  input  logic [IRQ_N-1:0]  mask_v,
  input  logic [REG_W-1:0]  gate_v,
  output logic [REG_W-1:0]  rdata,
  output logic              rvalid
);
  logic [REG_W-1:0] sel;

  always_comb begin
    sel = '0;
    if      (addr == ADDR_W'(OFS_BASE))  sel = base_v;
    else if (addr == ADDR_W'(OFS_STAT))  sel = stat_v;
    else if (addr == ADDR_W'(OFS_FADDR)) sel = faddr_v;
    else if (addr == ADDR_W'(OFS_RAW))   sel = REG_W'(raw_v);
    else if (addr == ADDR_W'(OFS_MASK))  sel = REG_W'(mask_v);
    else if (addr == ADDR_W'(OFS_MSTAT)) sel = REG_W'(raw_v & mask_v);
    else if (addr == ADDR_W'(OFS_GATE))  sel = gate_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= sel;
    end
  end

  // R12: every read strobe is answered on the next cycle
  a_r12_read_valid: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);
endmodule

// File: rtl/pgu_ctrl_regs.sv
module pgu_ctrl_regs
  import pgu_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int ID_W     = 5,
  parameter int BASE_LSB = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              eng_fault,
  input  logic [31:0]       eng_fault_addr,
  input  logic              eng_fault_wr,
  input  logic [ID_W-1:0]   eng_fault_id,
  input  logic              eng_buserr,
  input  logic              eng_idle,
  input  logic              eng_replay_empty,
  output logic              xl_paging,
  output logic              xl_stall,
  output logic              xl_flush_all,
  output logic              xl_flush_one,
  output logic [31:0]       xl_flush_addr,
  output logic              xl_resume,
  output logic [31:0]       xl_dir_base,
  output logic [31:0]       gate_cfg,
  output logic              irq
);
  localparam logic [REG_W-1:0] KEEP_MASK = ~((REG_W'(1) << BASE_LSB) - REG_W'(1));

  logic wr_base, wr_cmd, wr_inv1, wr_ack, wr_mask, wr_gate, hard_rst, wipe;
  logic             fault_act, fault_wr_q;
  logic [ID_W-1:0]  fault_id_q;
  logic [REG_W-1:0] fault_addr_q;
  logic [IRQ_N-1:0] raw_q, mask_q, ev;
  logic [REG_W-1:0] stat_w;

  assign wr_base  = bus_wr && (bus_addr == ADDR_W'(OFS_BASE));
  assign wr_cmd   = bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
  assign wr_inv1  = bus_wr && (bus_addr == ADDR_W'(OFS_INV1));
  assign wr_ack   = bus_wr && (bus_addr == ADDR_W'(OFS_ICLR));
  assign wr_mask  = bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
  assign wr_gate  = bus_wr && (bus_addr == ADDR_W'(OFS_GATE));
  assign hard_rst = wr_cmd && (bus_wdata == REG_W'(CMD_HARD_RST));
  assign wipe     = rst | hard_rst;

  always_ff @(posedge clk) begin
    if (wipe) begin
      xl_dir_base <= '0;
    end else if (wr_base) begin
      xl_dir_base <= bus_wdata & KEEP_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (wipe) begin
      gate_cfg <= '0;
    end else if (wr_gate) begin
      gate_cfg <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (wipe) begin
      xl_flush_one  <= 1'b0;
      xl_flush_addr <= '0;
    end else begin
      xl_flush_one <= wr_inv1;
      if (wr_inv1) xl_flush_addr <= bus_wdata;
    end
  end

  pgu_cmd_ctrl #(.ID_W(ID_W)) u_cmd (
    .clk          (clk),
    .rst          (rst),
    .clr          (hard_rst),
    .cmd_vld      (wr_cmd),
    .cmd_code     (bus_wdata),
    .fault_evt    (eng_fault),
    .fault_addr   (eng_fault_addr),
    .fault_wr     (eng_fault_wr),
    .fault_id     (eng_fault_id),
    .paging_q     (xl_paging),
    .stall_q      (xl_stall),
    .fault_act_q  (fault_act),
    .fault_wr_q   (fault_wr_q),
    .fault_id_q   (fault_id_q),
    .fault_addr_q (fault_addr_q),
    .flush_all_q  (xl_flush_all),
    .resume_q     (xl_resume)
  );

  always_comb begin
    ev = '0;
    ev[IRQ_FAULT]  = eng_fault;
    ev[IRQ_BUSERR] = eng_buserr;
  end

  pgu_irq_unit u_irq (
    .clk       (clk),
    .rst       (rst),
    .clr       (hard_rst),
    .ev        (ev),
    .ack_wr    (wr_ack),
    .ack_bits  (bus_wdata[IRQ_N-1:0]),
    .mask_wr   (wr_mask),
    .mask_bits (bus_wdata[IRQ_N-1:0]),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .irq_q     (irq)
  );

  always_comb begin
    stat_w = '0;
    stat_w[ST_PAGING] = xl_paging;
    stat_w[ST_FAULT]  = fault_act;
    stat_w[ST_STALL]  = xl_stall;
    stat_w[ST_IDLE]   = eng_idle;
    stat_w[ST_REPLAY] = eng_replay_empty;
    stat_w[ST_FWRITE] = fault_wr_q;
    stat_w[ST_ID_LSB +: ID_W] = fault_id_q;
    stat_w[ST_NSTALL] = ~xl_stall;
  end

  pgu_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd      (bus_rd),
    .addr    (bus_addr),
    .base_v  (xl_dir_base),
    .stat_v  (stat_w),
    .faddr_v (fault_addr_q),
    .raw_v   (raw_q),
    .mask_v  (mask_q),
    .gate_v  (gate_cfg),
    .rdata   (bus_rdata),
    .rvalid  (bus_rvalid)
  );

  // R2: stored base is the written word with the low bits cut off
  a_r2_base_trunc: assert property (@(posedge clk) disable iff (rst)
    (wr_base && !hard_rst) |=> (xl_dir_base == ($past(bus_wdata) & KEEP_MASK)));

  // R11: hard reset brings outputs back to power-on values
  a_r11_hard_reset: assert property (@(posedge clk) disable iff (rst)
    hard_rst |=> (!xl_paging && !xl_stall && !irq && (xl_dir_base == '0) && (gate_cfg == '0)));
endmodule

// File: tb/tb_pgu_ctrl_regs.sv
module tb_pgu_ctrl_regs;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        eng_fault = 1'b0;
  logic [31:0] eng_fault_addr = '0;
  logic        eng_fault_wr = 1'b0;
  logic [4:0]  eng_fault_id = '0;
  logic        eng_buserr = 1'b0;
  logic        eng_idle = 1'b1, eng_replay_empty = 1'b1;
  logic        xl_paging, xl_stall, xl_flush_all, xl_flush_one, xl_resume, irq;
  logic [31:0] xl_flush_addr, xl_dir_base, gate_cfg;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  pgu_ctrl_regs dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .eng_fault(eng_fault), .eng_fault_addr(eng_fault_addr), .eng_fault_wr(eng_fault_wr),
    .eng_fault_id(eng_fault_id), .eng_buserr(eng_buserr), .eng_idle(eng_idle),
    .eng_replay_empty(eng_replay_empty), .xl_paging(xl_paging), .xl_stall(xl_stall),
    .xl_flush_all(xl_flush_all), .xl_flush_one(xl_flush_one), .xl_flush_addr(xl_flush_addr),
    .xl_resume(xl_resume), .xl_dir_base(xl_dir_base), .gate_cfg(gate_cfg), .irq(irq)
  );

  function automatic logic [31:0] st(input logic pg, fa, sl, id, rp, fw, input logic [4:0] mid);
    logic [31:0] w;
    w = '0;
    w[0] = pg; w[1] = fa; w[2] = sl; w[3] = id; w[4] = rp; w[5] = fw;
    w[10:6] = mid; w[31] = ~sl;
    return w;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results as they come out
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R12: actual 0x%08h expected no read data", bus_rdata);
      end else begin
        chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic fault(input logic [31:0] fa, input logic w, input logic [4:0] id);
    @(negedge clk); eng_fault = 1'b1; eng_fault_addr = fa; eng_fault_wr = w; eng_fault_id = id;
    @(negedge clk); eng_fault = 1'b0;
  endtask

  task automatic berr();
    @(negedge clk); eng_buserr = 1'b1;
    @(negedge clk); eng_buserr = 1'b0;
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R12: actual %0d reads unanswered expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk({31'd0, irq}, 32'd0, "R1 irq");
    chk({31'd0, xl_paging}, 32'd0, "R1 paging");
    rd(8'h04, st(0,0,0,1,1,0,5'd0), "R1 status");
    rd(8'h00, 32'h0, "R1 base");
    // R2 truncation
    wr(8'h00, 32'hCAFEBABE);
    chk(xl_dir_base, 32'hCAFEB000, "R2 port");
    rd(8'h00, 32'hCAFEB000, "R2 read");
    // R3 paging
    wr(8'h08, 32'd0);
    chk({31'd0, xl_paging}, 32'd1, "R3 on");
    rd(8'h04, st(1,0,0,1,1,0,5'd0), "R3 status on");
    wr(8'h08, 32'd1);
    chk({31'd0, xl_paging}, 32'd0, "R3 off");
    // R13 engine flags
    eng_idle = 1'b0; eng_replay_empty = 1'b0;
    rd(8'h04, st(0,0,0,0,0,0,5'd0), "R13 flags low");
    eng_idle = 1'b1; eng_replay_empty = 1'b1;
    // R4 stall
    wr(8'h08, 32'd2);
    chk({31'd0, xl_stall}, 32'd1, "R4 stall on");
    rd(8'h04, st(0,0,1,1,1,0,5'd0), "R4 status stall");
    wr(8'h08, 32'd3);
    chk({31'd0, xl_stall}, 32'd0, "R4 stall off");
    // R5 flush pulses
    wr(8'h08, 32'd4);
    chk({31'd0, xl_flush_all}, 32'd1, "R5 flush all high");
    @(negedge clk);
    chk({31'd0, xl_flush_all}, 32'd0, "R5 flush all one cycle");
    wr(8'h10, 32'h12345000);
    chk({31'd0, xl_flush_one}, 32'd1, "R5 flush one");
    chk(xl_flush_addr, 32'h12345000, "R5 flush addr");
    @(negedge clk);
    chk({31'd0, xl_flush_one}, 32'd0, "R5 flush one one cycle");
    // R12 unknown command, gating word, write-only reads
    wr(8'h08, 32'd7);
    rd(8'h04, st(0,0,0,1,1,0,5'd0), "R12 cmd 7 ignored");
    chk({31'd0, xl_paging}, 32'd0, "R12 cmd 7 paging");
    wr(8'h24, 32'hA5A5_0F0F);
    rd(8'h24, 32'hA5A5_0F0F, "R12 gate");
    rd(8'h08, 32'h0, "R12 cmd reads 0");
    // R6 fault
    wr(8'h1C, 32'd3);
    fault(32'hDEAD1234, 1'b1, 5'd31);
    chk({31'd0, irq}, 32'd1, "R9 irq on fault");
    rd(8'h0C, 32'hDEAD1234, "R6 fault addr");
    rd(8'h04, st(0,1,0,1,1,1,5'd31), "R6 status fault");
    rd(8'h14, 32'd1, "R6 raw");
    wr(8'h08, 32'd2);
    chk({31'd0, xl_stall}, 32'd0, "R4 stall ignored in fault");
    // R7 fault done
    wr(8'h08, 32'd5);
    chk({31'd0, xl_resume}, 32'd1, "R7 resume");
    rd(8'h04, st(0,0,0,1,1,1,5'd31), "R7 status after done");
    chk({31'd0, xl_resume}, 32'd0, "R7 resume one cycle");
    // R7 done racing a new fault
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'd5;
    eng_fault = 1'b1; eng_fault_addr = 32'h0000_2000; eng_fault_wr = 1'b0; eng_fault_id = 5'd3;
    @(negedge clk); bus_wr = 1'b0; eng_fault = 1'b0;
    chk({31'd0, xl_resume}, 32'd0, "R7 no resume on race");
    rd(8'h04, st(0,1,0,1,1,0,5'd3), "R7 fault kept on race");
    wr(8'h08, 32'd5);
    // R8 bus error
    berr();
    rd(8'h14, 32'd3, "R8 both raw");
    rd(8'h20, 32'd3, "R9 masked both");
    // R10 clears
    wr(8'h18, 32'd1);
    rd(8'h14, 32'd2, "R10 clear bit0");
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'd2; eng_buserr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; eng_buserr = 1'b0;
    rd(8'h14, 32'd2, "R10 event wins");
    wr(8'h18, 32'd2);
    chk({31'd0, irq}, 32'd0, "R10 irq after clear");
    rd(8'h14, 32'd0, "R10 raw clear");
    // R9 masking
    wr(8'h1C, 32'd2);
    fault(32'h0000_3000, 1'b0, 5'd1);
    chk({31'd0, irq}, 32'd0, "R9 masked fault");
    rd(8'h20, 32'd0, "R9 masked zero");
    berr();
    chk({31'd0, irq}, 32'd1, "R9 bus error unmasked");
    rd(8'h20, 32'd2, "R9 masked bit1");
    // R11 hard reset
    wr(8'h08, 32'd0);
    wr(8'h00, 32'h8000_0000);
    wr(8'h08, 32'd6);
    chk({31'd0, xl_paging}, 32'd0, "R11 paging");
    chk(xl_dir_base, 32'h0, "R11 base port");
    chk({31'd0, irq}, 32'd0, "R11 irq");
    rd(8'h14, 32'd0, "R11 raw");
    rd(8'h1C, 32'd0, "R11 mask");
    rd(8'h24, 32'd0, "R11 gate");
    rd(8'h0C, 32'd0, "R11 fault addr");
    rd(8'h04, st(0,0,0,1,1,0,5'd0), "R11 status");
    finish_run();
  end
endmodule